// File: doc/BRIEF.md
# Two-Stage Bus Watchdog Timer

This block is a watchdog timer behind a simple 32-bit register bus with a single-cycle strobe. A down-counter is reloaded from a programmable load value and loses one count per clock while the run bit is set. The first time the count runs out, the block raises an interrupt flag and reloads. If the flag is still pending when the count runs out again, and the reset-enable bit is also set, a system reset output goes high and stays high until the block itself is reset.

Software services the watchdog by writing the interrupt clear register. That clears the flag and also restarts the countdown. All register writes are refused unless the block has first been unlocked with a 32-bit key. The live count, the raw flag and the masked flag can be read back. Because a load value of zero expires on the next clock, writing it is a quick way to force an immediate restart.

Top module: `wdg_timer`

## Requirements
- R1: After reset the load register and the count read 0xFFFFFFFF, control reads 0, both status registers read 0, the lock register reads 1, and `irq_o` and `sysrst_o` are low.
- R2: A write of 0x1ACCE551 to the lock register (offset 0xC00) unlocks, and it then reads 0. A write of any other value locks, and it then reads 1. Writes to this register are always accepted.
- R3: While locked, writes to the load (0x000), control (0x008) and interrupt clear (0x00C) registers change nothing.
- R4: While control bit 0 is set, a count at zero sets the raw flag and reloads from the load register, so the flag rises load+1 clocks after a reload.
- R5: When the count reaches zero with the raw flag pending and control bits 0 and 1 both set, `sysrst_o` rises one clock later and stays high until the block's reset.
- R6: With only control bit 0 set, repeated expiries never assert `sysrst_o`.
- R7: A write of any value to the interrupt clear register clears the raw flag and reloads the count from the load register.
- R8: Bit 0 of raw status (0x010) is the flag. Bit 0 of masked status (0x014) and `irq_o` are the flag ANDed with control bit 0.
- R9: Clearing control bit 0 freezes the count at its value. Setting it again reloads the count from the load register.
- R10: A load write reloads the count at once. A load of 0 sets the flag on the next clock.
- R11: Read data appears on `bus_rdata` the clock after the read strobe. The count register (0x004) is read-only, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Masked interrupt |
| sysrst_o | output | 1 | Sticky system reset request |

## Verification
- **Writes:** every register write takes effect at the clock edge that samples the strobe. The bench therefore counts clocks from the negative edge that follows that write.
- **Reads:** a read returns the value held just before its sampling edge, and it is checked on the next negative edge.
- **Interrupt and reset timing:** after a reload to value L, the flag is due at the (L+1)th negative edge and the reset at the (2L+2)th. The bench checks one edge before each event (still low) and the event edge itself (high), so an off-by-one in either direction fails.
- **Service and freeze:** a service write or a freeze is followed at once by a count readback whose expected value is worked out from the same edge count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [11:0] OFF_LOAD  = 12'h000;
  localparam logic [11:0] OFF_COUNT = 12'h004;
  localparam logic [11:0] OFF_CTRL  = 12'h008;
  localparam logic [11:0] OFF_ICLR  = 12'h00C;
  localparam logic [11:0] OFF_RAW   = 12'h010;
  localparam logic [11:0] OFF_MASK  = 12'h014;
  localparam logic [11:0] OFF_LOCK  = 12'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LOAD, SEL_COUNT, SEL_CTRL,
    SEL_ICLR, SEL_RAW, SEL_MASK, SEL_LOCK
  } reg_sel_e;
endpackage

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             rst_en,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             sysrst_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             sysrst_q;
  logic             at_zero;
  logic             expire;

  assign at_zero = (cnt_q == '0);
  // an explicit reload (bus command) outranks a same-cycle expiry
  assign expire  = run_en && at_zero && !reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '1;
      flag_q   <= 1'b0;
      sysrst_q <= 1'b0;
    end else begin
      if (reload)
        cnt_q <= reload_val;
      else if (run_en)
        cnt_q <= at_zero ? reload_val : cnt_q - 1'b1;

      if (flag_clr)
        flag_q <= 1'b0;
      else if (expire)
        flag_q <= 1'b1;

      if (expire && flag_q && rst_en && !flag_clr)
        sysrst_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign flag_o   = flag_q;
  assign sysrst_o = sysrst_q;

  // R4: the flag only rises after a running count sat at zero
  assert_flag_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(run_en && cnt_q == '0));

  // R5: once asserted, the reset request holds
  assert_rst_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    sysrst_q |=> sysrst_q);

  // R5: the reset request needs a pending flag, both enables and a zero count
  assert_rst_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sysrst_q) |-> $past(flag_q && run_en && rst_en && cnt_q == '0));

  // R9: a stopped count with no reload command holds its value
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              flag_i,
  output logic              run_en,
  output logic              rst_en,
  output logic              reload,
  output logic [DATA_W-1:0] reload_val,
  output logic              flag_clr
);
  localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

  reg_sel_e          sel;
  logic [DATA_W-1:0] load_q;
  logic [1:0]        ctrl_q;
  logic              locked_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_any;
  logic              wr_ok;
  logic              load_wr;
  logic              ctrl_wr;
  logic              iclr_wr;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFF_LOAD):  sel = SEL_LOAD;
      ADDR_W'(OFF_COUNT): sel = SEL_COUNT;
      ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
      ADDR_W'(OFF_ICLR):  sel = SEL_ICLR;
      ADDR_W'(OFF_RAW):   sel = SEL_RAW;
      ADDR_W'(OFF_MASK):  sel = SEL_MASK;
      ADDR_W'(OFF_LOCK):  sel = SEL_LOCK;
      default:            sel = SEL_NONE;
    endcase
  end

  assign wr_any  = bus_sel && bus_wr;
  assign wr_ok   = wr_any && !locked_q;
  assign load_wr = wr_ok && (sel == SEL_LOAD);
  assign ctrl_wr = wr_ok && (sel == SEL_CTRL);
  assign iclr_wr = wr_ok && (sel == SEL_ICLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= '1;
      ctrl_q   <= 2'b00;
      locked_q <= 1'b1;
    end else begin
      if (load_wr) load_q <= bus_wdata;
      if (ctrl_wr) ctrl_q <= bus_wdata[1:0];
      if (wr_any && sel == SEL_LOCK) locked_q <= (bus_wdata != KEY);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_LOAD:  rd_mux = load_q;
      SEL_COUNT: rd_mux = cnt_i;
      SEL_CTRL:  rd_mux = DATA_W'(ctrl_q);
      SEL_RAW:   rd_mux = DATA_W'(flag_i);
      SEL_MASK:  rd_mux = DATA_W'(flag_i & ctrl_q[0]);
      SEL_LOCK:  rd_mux = DATA_W'(locked_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= (bus_sel && !bus_wr) ? rd_mux : '0;
  end

  assign bus_rdata  = rdata_q;
  assign run_en     = ctrl_q[0];
  assign rst_en     = ctrl_q[1];
  assign reload     = load_wr || iclr_wr || (ctrl_wr && bus_wdata[0] && !ctrl_q[0]);
  assign reload_val = load_wr ? bus_wdata : load_q;
  assign flag_clr   = iclr_wr;

  // R3: a locked block ignores writes to its data registers
  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_any && locked_q && sel != SEL_LOCK) |=> ($stable(load_q) && $stable(ctrl_q)));

  // R2: the key always unlocks
  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_any && sel == SEL_LOCK && bus_wdata == KEY) |=> !locked_q);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sysrst_o
);
  logic              run_en;
  logic              rst_en;
  logic              reload;
  logic [DATA_W-1:0] reload_val;
  logic              flag_clr;
  logic [DATA_W-1:0] cnt;
  logic              flag;

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_i(cnt), .flag_i(flag), .run_en(run_en), .rst_en(rst_en),
    .reload(reload), .reload_val(reload_val), .flag_clr(flag_clr)
  );

  wdg_count #(.CNT_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .run_en(run_en), .rst_en(rst_en),
    .reload(reload), .reload_val(reload_val), .flag_clr(flag_clr),
    .cnt_o(cnt), .flag_o(flag), .sysrst_o(sysrst_o)
  );

  assign irq_o = flag & run_en;

  // R8: the interrupt pin never shows while the counter is stopped
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (flag && run_en));
endmodule

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        sysrst_o;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wdg_timer u_wdg_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sysrst_o(sysrst_o)
  );

  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
    A_ICLR = 12'h00C, A_RAW = 12'h010, A_MASK = 12'h014, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a negative edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 sysrst_o", 32'(sysrst_o), 0);
    rd(A_LOAD, d); chk("R1 load", d, 32'hFFFFFFFF);
    rd(A_CNT, d);  chk("R1 count", d, 32'hFFFFFFFF);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_RAW, d);  chk("R1 raw", d, 0);
    rd(A_MASK, d); chk("R1 masked", d, 0);
    rd(A_LOCK, d); chk("R1 lock", d, 1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(A_LOAD, 32'd7); wr(A_CTRL, 32'd3);
    rd(A_LOAD, d); chk("R3 locked load", d, 32'hFFFFFFFF);
    rd(A_CTRL, d); chk("R3 locked ctrl", d, 0);
    wr(A_LOCK, KEY);
    rd(A_LOCK, d); chk("R2 unlocked", d, 0);
    wr(A_LOAD, 32'd20);
    rd(A_CNT, d); chk("R10 load reloads count", d, 32'd20);
    wr(A_LOCK, 32'h1ACCE550);
    rd(A_LOCK, d); chk("R2 relocked", d, 1);
    wr(A_LOAD, 32'd5);
    rd(A_LOAD, d); chk("R3 load after relock", d, 32'd20);
    wr(A_CNT, 32'd3);
    rd(A_CNT, d); chk("R11 count read-only", d, 32'd20);
    rd(12'h020, d); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_first_expiry();
    logic [31:0] d;
    do_reset();
    wr(A_LOCK, KEY); wr(A_LOAD, 32'd9); wr(A_CTRL, 32'd1);
    repeat (9) @(negedge clk);
    chk("R4 no flag at k=9", 32'(irq_o), 0);
    @(negedge clk);
    chk("R4 flag at k=10", 32'(irq_o), 1);
    wr(A_CTRL, 32'd0);
    chk("R8 irq_o masked", 32'(irq_o), 0);
    rd(A_RAW, d);  chk("R8 raw", d, 1);
    rd(A_MASK, d); chk("R8 masked", d, 0);
  endtask

  task automatic t_second_expiry();
    do_reset();
    wr(A_LOCK, KEY); wr(A_LOAD, 32'd9); wr(A_CTRL, 32'd3);
    repeat (10) @(negedge clk);
    chk("R4 flag before reset", 32'(irq_o), 1);
    repeat (9) @(negedge clk);
    chk("R5 no reset at k=19", 32'(sysrst_o), 0);
    @(negedge clk);
    chk("R5 reset at k=20", 32'(sysrst_o), 1);
    wr(A_CTRL, 32'd0); wr(A_ICLR, 32'd0);
    repeat (3) @(negedge clk);
    chk("R5 reset sticky", 32'(sysrst_o), 1);
  endtask

  task automatic t_bit0_only();
    do_reset();
    wr(A_LOCK, KEY); wr(A_LOAD, 32'd4); wr(A_CTRL, 32'd1);
    repeat (22) @(negedge clk);
    chk("R6 no reset with bit0 only", 32'(sysrst_o), 0);
    chk("R6 flag still set", 32'(irq_o), 1);
  endtask

  task automatic t_intclr();
    logic [31:0] d;
    do_reset();
    wr(A_LOCK, KEY); wr(A_LOAD, 32'd9); wr(A_CTRL, 32'd3);
    repeat (13) @(negedge clk);
    wr(A_ICLR, 32'hDEAD);
    chk("R7 flag cleared", 32'(irq_o), 0);
    rd(A_CNT, d); chk("R7 count reloaded", d, 32'd9);
    repeat (8) @(negedge clk);
    chk("R7 flag low before new expiry", 32'(irq_o), 0);
    @(negedge clk);
    chk("R7 flag after new expiry", 32'(irq_o), 1);
    chk("R7 no reset after service", 32'(sysrst_o), 0);
  endtask

  task automatic t_hold();
    logic [31:0] a;
    logic [31:0] b;
    do_reset();
    wr(A_LOCK, KEY); wr(A_LOAD, 32'd50); wr(A_CTRL, 32'd1);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'd0);
    rd(A_CNT, a); chk("R9 frozen value", a, 32'd39);
    repeat (5) @(negedge clk);
    rd(A_CNT, b); chk("R9 still frozen", b, 32'd39);
    wr(A_CTRL, 32'd1);
    rd(A_CNT, a); chk("R9 reload on enable", a, 32'd50);
  endtask

  task automatic t_load_zero();
    do_reset();
    wr(A_LOCK, KEY); wr(A_CTRL, 32'd3); wr(A_LOAD, 32'd0);
    chk("R10 no flag yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R10 flag next clock", 32'(irq_o), 1);
    chk("R10 no reset yet", 32'(sysrst_o), 0);
    @(negedge clk);
    chk("R10 reset follows", 32'(sysrst_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lock();
    t_first_expiry();
    t_second_expiry();
    t_bit0_only();
    t_intclr();
    t_hold();
    t_load_zero();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule